// File: doc/BRIEF.md
# Processor-to-Peripheral Strobe Adapter

This block sits between a processor with a multiplexed address/data bus and a peripheral that expects a single data strobe, a read/write level and an active-low address strobe. It samples the processor's bus control signals on the system clock and produces registered control signals for the peripheral. The address strobe is the inverted address latch enable. The data strobe goes low while a read or write command is active. The read/write level follows the processor's transmit/receive direction signal.

At the rising edge of the derived address strobe, the block captures two things from the multiplexed bus: a chip-select decision and two register-select bits. Both are held until the next address phase. The chip-select decision is a masked compare against a fixed I/O address. A mode parameter chooses where the signals come from. In minimum mode, the data strobe is built from the plain read and write strobes, and the memory/IO qualifier must show an I/O cycle before chip select can be granted. In maximum mode, the data strobe is built from the bus controller's I/O read command and advanced I/O write command, and the qualifier is not used. The peripheral's control/key mode input is held low so that it stays in multiplexed control mode.

Top module: `strobe_adapter`

## Requirements
- R1: `as_n` equals the inverse of `ale` as sampled at the previous rising clock edge.
- R2: When `as_n` goes from low to high, `rsel` loads `ad_bus[2:1]` as sampled at that same clock edge (default `RSEL_LSB` = 1).
- R3: At that same edge, `cs_n` loads 0 when `(ad_bus ^ DEC_MATCH) & DEC_MASK` is zero and, in minimum mode, `mio_n` is 0; otherwise it loads 1. The defaults are mask 16'hFF00 and match 16'hFC00.
- R4: Between address-strobe rising edges, `cs_n` and `rsel` keep their values, whatever happens on `ad_bus` and `mio_n`.
- R5: In minimum mode (the default), `ds_n` is low one cycle after `rd_n` or `wr_n` was low, and high one cycle after both were high.
- R6: In maximum mode, `ds_n` follows the AND of `iorc_n` and `aiowc_n` one cycle later, and `mio_n` has no effect on the chip-select decision.
- R7: `rw` equals `dtr` as sampled at the previous rising clock edge.
- R8: While `rst_n` is low, `as_n`, `ds_n`, `cs_n` and `rw` are 1 and `rsel` is all ones.
- R9: `ctl_key` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale | input | 1 | Processor address latch enable, active high |
| ad_bus | input | BUS_W | Multiplexed address/data lines |
| mio_n | input | 1 | Memory/IO qualifier, low for I/O cycles (minimum mode) |
| rd_n | input | 1 | Read strobe (minimum mode) |
| wr_n | input | 1 | Write strobe (minimum mode) |
| iorc_n | input | 1 | I/O read command from bus controller (maximum mode) |
| aiowc_n | input | 1 | Advanced I/O write command (maximum mode) |
| dtr | input | 1 | Data transmit/receive direction, 1 = write |
| as_n | output | 1 | Peripheral address strobe, active low |
| ds_n | output | 1 | Peripheral data strobe, active low |
| rw | output | 1 | Peripheral read/write level |
| cs_n | output | 1 | Latched chip select, active low |
| rsel | output | RSEL_W | Latched register-select bits |
| ctl_key | output | 1 | Control/key mode select, held low |

## Verification
The assertions assume that an address phase raises `ale` for at least one clock, and that the address is still valid on `ad_bus` at the clock edge where `ale` is first seen low, since that is the edge at which the capture happens. The stimulus always holds the address through that edge. Only after that edge does it put data values on `ad_bus` and flip `mio_n`. It also keeps the read and write strobes inactive during the address phase. The same stimulus drives a minimum-mode instance and a maximum-mode instance side by side, so both ways of sourcing the signals are checked against one expected model.

// File: rtl/adapter_pkg.sv
package adapter_pkg;
   typedef enum logic {
      MODE_MIN = 1'b0,
      MODE_MAX = 1'b1
   } bus_mode_e;
endpackage

// File: rtl/sa_cs_decode.sv
module sa_cs_decode #(
   parameter adapter_pkg::bus_mode_e MODE = adapter_pkg::MODE_MIN,
   parameter int unsigned BUS_W     = 16,
   parameter logic [BUS_W-1:0] DEC_MASK  = 16'hFF00,
   parameter logic [BUS_W-1:0] DEC_MATCH = 16'hFC00
) (
   input  logic [BUS_W-1:0] ad_bus,
   input  logic             mio_n,
   output logic             hit
);
   logic addr_ok;
   logic cycle_ok;

   assign addr_ok  = ((ad_bus ^ DEC_MATCH) & DEC_MASK) == '0;
   // only I/O cycles may select the peripheral when the qualifier is in use
   assign cycle_ok = (MODE == adapter_pkg::MODE_MIN) ? ~mio_n : 1'b1;
   assign hit      = addr_ok & cycle_ok;
endmodule

// File: rtl/sa_strobe_regs.sv
module sa_strobe_regs #(
   parameter adapter_pkg::bus_mode_e MODE = adapter_pkg::MODE_MIN
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ale,
   input  logic rd_n,
   input  logic wr_n,
   input  logic iorc_n,
   input  logic aiowc_n,
   input  logic dtr,
   output logic as_n,
   output logic ds_n,
   output logic rw,
   output logic capture
);
   logic ds_src;

   assign ds_src = (MODE == adapter_pkg::MODE_MIN) ? (rd_n & wr_n)
                                                   : (iorc_n & aiowc_n);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         as_n <= 1'b1;
         ds_n <= 1'b1;
         rw   <= 1'b1;
      end else begin
         as_n <= ~ale;
         ds_n <= ds_src;
         rw   <= dtr;
      end
   end

   // as_n is about to rise: the latch enable was high last cycle, low now
   assign capture = ~as_n & ~ale;

   // R1
   as_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !as_n);
   // R1
   as_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> as_n);
   // R7
   rw_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dtr |=> rw);

   if (MODE == adapter_pkg::MODE_MIN) begin : g_min_chk
      // R5
      ds_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_n || !wr_n) |=> !ds_n);
   end else begin : g_max_chk
      // R6
      ds_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!iorc_n || !aiowc_n) |=> !ds_n);
   end
endmodule

// File: rtl/sa_addr_latch.sv
module sa_addr_latch #(
   parameter int unsigned RSEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              hit,
   input  logic [RSEL_W-1:0] rsel_in,
   output logic              cs_n,
   output logic [RSEL_W-1:0] rsel
);
   for (genvar b = 0; b < RSEL_W; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)       rsel[b] <= 1'b1;
         else if (capture) rsel[b] <= rsel_in[b];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       cs_n <= 1'b1;
      else if (capture) cs_n <= ~hit;
   end

   // R2
   rsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> rsel == $past(rsel_in));
   // R3
   cs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> cs_n == !$past(hit));
   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(rsel) && $stable(cs_n)));
endmodule

// File: rtl/strobe_adapter.sv
module strobe_adapter #(
   parameter adapter_pkg::bus_mode_e MODE = adapter_pkg::MODE_MIN,
   parameter int unsigned BUS_W    = 16,
   parameter int unsigned RSEL_W   = 2,
   parameter int unsigned RSEL_LSB = 1,
   parameter logic [BUS_W-1:0] DEC_MASK  = 16'hFF00,
   parameter logic [BUS_W-1:0] DEC_MATCH = 16'hFC00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [BUS_W-1:0]  ad_bus,
   input  logic              mio_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              iorc_n,
   input  logic              aiowc_n,
   input  logic              dtr,
   output logic              as_n,
   output logic              ds_n,
   output logic              rw,
   output logic              cs_n,
   output logic [RSEL_W-1:0] rsel,
   output logic              ctl_key
);
   localparam int unsigned RSEL_MSB = RSEL_LSB + RSEL_W - 1;

   if (RSEL_W < 1 || RSEL_MSB >= BUS_W) begin : g_bad_rsel
      $error("register-select field does not fit the bus");
   end

   logic capture;
   logic hit;

   sa_strobe_regs #(.MODE(MODE)) u_strobes (
      .clk     (clk),
      .rst_n   (rst_n),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .iorc_n  (iorc_n),
      .aiowc_n (aiowc_n),
      .dtr     (dtr),
      .as_n    (as_n),
      .ds_n    (ds_n),
      .rw      (rw),
      .capture (capture)
   );

   sa_cs_decode #(
      .MODE      (MODE),
      .BUS_W     (BUS_W),
      .DEC_MASK  (DEC_MASK),
      .DEC_MATCH (DEC_MATCH)
   ) u_decode (
      .ad_bus (ad_bus),
      .mio_n  (mio_n),
      .hit    (hit)
   );

   sa_addr_latch #(.RSEL_W(RSEL_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .hit     (hit),
      .rsel_in (ad_bus[RSEL_MSB:RSEL_LSB]),
      .cs_n    (cs_n),
      .rsel    (rsel)
   );

   // multiplexed control mode is permanently selected
   assign ctl_key = 1'b0;
endmodule

// File: tb/test_strobe_adapter.sv
module test_strobe_adapter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ale = 1'b0;
   logic [15:0] ad_bus = '0;
   logic        mio_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        iorc_n = 1'b1, aiowc_n = 1'b1, dtr = 1'b0;

   logic       as_n, ds_n, rw, cs_n, ctl_key;
   logic [1:0] rsel;
   logic       as_x, ds_x, rw_x, cs_x, key_x;
   logic [1:0] rsel_x;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   strobe_adapter i_strobe_adapter (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_bus(ad_bus), .mio_n(mio_n),
      .rd_n(rd_n), .wr_n(wr_n), .iorc_n(iorc_n), .aiowc_n(aiowc_n), .dtr(dtr),
      .as_n(as_n), .ds_n(ds_n), .rw(rw), .cs_n(cs_n), .rsel(rsel),
      .ctl_key(ctl_key));

   strobe_adapter #(.MODE(adapter_pkg::MODE_MAX)) i_strobe_adapter_max (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_bus(ad_bus), .mio_n(mio_n),
      .rd_n(rd_n), .wr_n(wr_n), .iorc_n(iorc_n), .aiowc_n(aiowc_n), .dtr(dtr),
      .as_n(as_x), .ds_n(ds_x), .rw(rw_x), .cs_n(cs_x), .rsel(rsel_x),
      .ctl_key(key_x));

   typedef struct {
      logic       as_n;
      logic       ds_min;
      logic       ds_max;
      logic       rw;
      logic       cs_min;
      logic       cs_max;
      logic [1:0] rsel;
   } item_t;

   item_t exp_q[$];

   logic       m_ale_prev = 1'b0;
   logic       m_cs = 1'b1, m_csx = 1'b1;
   logic [1:0] m_rsel = 2'b11;

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(logic a, logic [15:0] ad, logic mio, logic rd, logic wr,
                       logic iorc, logic aiowc, logic dir);
      item_t it;
      logic  addr_hit;
      @(negedge clk);
      ale = a; ad_bus = ad; mio_n = mio; rd_n = rd; wr_n = wr;
      iorc_n = iorc; aiowc_n = aiowc; dtr = dir;
      if (m_ale_prev && !a) begin
         addr_hit = ((ad ^ 16'hFC00) & 16'hFF00) == 16'h0000;
         m_cs   = !(addr_hit && !mio);
         m_csx  = !addr_hit;
         m_rsel = ad[2:1];
      end
      m_ale_prev = a;
      it.as_n   = !a;
      it.ds_min = rd & wr;
      it.ds_max = iorc & aiowc;
      it.rw     = dir;
      it.cs_min = m_cs;
      it.cs_max = m_csx;
      it.rsel   = m_rsel;
      exp_q.push_back(it);
   endtask

   // monitor: compares each queued item just after the edge that produces it
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         item_t e;
         e = exp_q.pop_front();
         chk("R1 as_n min", {7'd0, as_n}, {7'd0, e.as_n});
         chk("R1 as_n max", {7'd0, as_x}, {7'd0, e.as_n});
         chk("R5 ds_n min", {7'd0, ds_n}, {7'd0, e.ds_min});
         chk("R6 ds_n max", {7'd0, ds_x}, {7'd0, e.ds_max});
         chk("R7 rw", {6'd0, rw, rw_x}, {6'd0, e.rw, e.rw});
         chk("R3/R4 cs_n min", {7'd0, cs_n}, {7'd0, e.cs_min});
         chk("R6/R4 cs_n max", {7'd0, cs_x}, {7'd0, e.cs_max});
         chk("R2/R4 rsel", {4'd0, rsel, rsel_x}, {4'd0, e.rsel, e.rsel});
         chk("R9 ctl_key", {6'd0, ctl_key, key_x}, 8'd0);
      end
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state while drive pins toggle
      repeat (2) @(negedge clk);
      ale = 1'b1; rd_n = 1'b0; dtr = 1'b0;
      @(posedge clk); #1;
      chk("R8 reset strobes", {4'd0, as_n, ds_n, rw, cs_n},
          8'h0F);
      chk("R8 reset rsel", {6'd0, rsel}, 8'h03);
      chk("R8 reset max", {4'd0, as_x, ds_x, cs_x, rw_x}, 8'h0F);
      @(negedge clk);
      ale = 1'b0; rd_n = 1'b1;
      rst_n = 1'b1;

      // idle
      step(0, 16'h0000, 1, 1, 1, 1, 1, 0);
      step(0, 16'h0000, 1, 1, 1, 1, 1, 0);
      // I/O read at FC04, register 2: R2, R3
      step(1, 16'hFC04, 0, 1, 1, 1, 1, 0);
      step(0, 16'hFC04, 0, 1, 1, 1, 1, 0);
      // data phase: bus and qualifier change, latch holds (R4)
      step(0, 16'h00FF, 1, 0, 1, 0, 1, 0);
      step(0, 16'hFFFF, 1, 0, 1, 0, 1, 0);
      step(0, 16'h0000, 1, 1, 1, 1, 1, 0);
      // memory cycle at FC06: min refuses, max ignores qualifier (R3, R6)
      step(1, 16'hFC06, 1, 1, 1, 1, 1, 1);
      step(0, 16'hFC06, 1, 1, 1, 1, 1, 1);
      step(0, 16'h1234, 0, 1, 0, 1, 0, 1);
      step(0, 16'hABCD, 0, 1, 0, 1, 0, 1);
      step(0, 16'h0000, 1, 1, 1, 1, 1, 0);
      // I/O cycle at a non-matching address, register 1
      step(1, 16'h1202, 0, 1, 1, 1, 1, 0);
      step(1, 16'h1202, 0, 1, 1, 1, 1, 0);
      step(0, 16'h1202, 0, 1, 1, 1, 1, 0);
      step(0, 16'hFC00, 0, 0, 1, 1, 0, 0);
      // mixed strobe patterns for both data strobe sources (R5, R6, R7)
      step(0, 16'hFC00, 0, 1, 0, 0, 1, 1);
      step(0, 16'hFC00, 0, 0, 0, 1, 1, 1);
      step(0, 16'hFC00, 0, 1, 1, 0, 0, 0);
      // edge of decode mask: low byte ignored, register 0
      step(1, 16'hFCF9, 0, 1, 1, 1, 1, 0);
      step(0, 16'hFCF9, 0, 1, 1, 1, 1, 0);
      step(0, 16'hFD00, 1, 1, 1, 1, 1, 0);
      step(1, 16'hFD00, 0, 1, 1, 1, 1, 0);
      step(0, 16'hFD00, 0, 1, 1, 1, 1, 0);
      step(0, 16'h0000, 1, 1, 1, 1, 1, 0);
      @(posedge clk); #2;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule